// File: doc/BRIEF.md
# Protected Page-Write Commit Controller

This block sits behind a two-wire serial front-end, which turns bus traffic into single-cycle strobes, and in front of a storage array with slow writes. During a write transaction it gathers the data bytes into a one-page buffer. Nothing reaches storage until a Stop ends the transaction. At that point the whole page burst is drained to storage, one byte per cycle, and a fixed programming interval follows.

Every commit is gated by a volatile protection register that cannot be read back. It resets to the locked state and holds one nibble per region. General-purpose memory is the upper half of the address space. Configuration registers are the lower half. A transaction whose pointer is the protection address loads that register on Stop, and this load is never itself blocked.

A commit to a locked region is silently discarded and sets a sticky refusal flag. While a commit is in progress the block is busy, and storage address bytes are not acknowledged.

Top module: `pcc_top`

## Requirements
- R1: After reset, busy_o and refused_o are low, store_we_o is low, and both regions are locked, so a configuration write issued straight after reset stores nothing.
- R2: A write transaction is a Start, an acknowledged address byte (addr_hit_i), a pointer byte, and N data bytes (1..16). It is ended by Stop. That Stop makes store_we_o high for exactly N cycles, starting in the cycle after Stop. Byte i goes to address pointer+i, in arrival order.
- R3: Addresses stay inside the pointer's 16-byte page, and the low 4 bits wrap from 0xF to 0x0. If more than 16 bytes arrive, exactly 16 writes are committed, and a later byte overwrites the earlier byte of the same page offset.
- R4: A transaction ended by a Start instead of a Stop commits nothing. rd_ptr_o still shows the pointer advanced by one for each data byte taken.
- R5: When the pointer byte is 0x42, the first data byte is loaded into the protection register on Stop. This load produces no store write and no busy period, and it is accepted even while both regions are locked.
- R6: Memory (pointer bit 7 = 1) is writable only while protection bits [7:4] equal 0101. Configuration (pointer bit 7 = 0) is writable only while bits [3:0] equal 0101. Any other nibble value locks that region.
- R7: A commit to a locked region produces no store write and no busy period, and it sets refused_o. refused_o then stays high until reset.
- R8: busy_o stays high for N + PROG_CYCLES cycles after a commit (N = bytes written). While busy, addr_ack_o stays low for addr_hit_i, and bytes and Stop of that unacknowledged transaction are ignored.
- R9: A Stop with no data byte taken, and data strobes outside an acknowledged transaction, write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start or repeated Start strobe |
| stop_i | input | 1 | Stop strobe |
| addr_hit_i | input | 1 | Device address byte for storage matched |
| ptr_load_i | input | 1 | Pointer byte strobe |
| ptr_i | input | 8 | Pointer byte value |
| data_we_i | input | 1 | Write data byte strobe |
| data_i | input | 8 | Write data byte |
| addr_ack_o | output | 1 | Acknowledge for the address byte |
| rd_ptr_o | output | 8 | Current pointer, for reads |
| store_addr_o | output | 8 | Storage write address |
| store_data_o | output | 8 | Storage write data |
| store_we_o | output | 1 | Storage write enable |
| busy_o | output | 1 | Commit in progress |
| refused_o | output | 1 | Sticky: a commit was dropped because its region was locked |

## Verification
The assertions take for granted that the front-end raises at most one strobe per cycle, each for a single cycle, and never Start and Stop together. They also take for granted that an address hit comes only after a Start, so a commit can launch only from an idle controller. The stimulus issues strobes one at a time on the falling clock edge, in legal bus order. It waits for busy to clear between scenarios, except in the one scenario that deliberately probes the address acknowledge during a commit.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_WRITE = 2'd1,
    CS_PROG  = 2'd2
  } commit_state_t;

  localparam logic [3:0] OPEN_CODE = 4'b0101;

  function automatic logic nibble_open(input logic [3:0] nib);
    return nib == OPEN_CODE;
  endfunction
endpackage

// File: rtl/pcc_protect.sv
module pcc_protect
  import pcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_i,
  input  logic       load_i,
  input  logic [7:0] val_i,
  output logic       mem_open_o,
  output logic       cfg_open_o
);
  logic [7:0] prot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      prot_q <= 8'h00;
    else if (load_i) prot_q <= val_i;
  end

  assign mem_open_o = nibble_open(prot_q[7:4]);
  assign cfg_open_o = nibble_open(prot_q[3:0]);

  assert_prot_on_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prot_q) |-> $past(stop_i));
endmodule

// File: rtl/pcc_pagebuf.sv
module pcc_pagebuf #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int PAGE_LG = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               open_i,
  input  logic               ptr_load_i,
  input  logic [AW-1:0]      ptr_i,
  input  logic               data_we_i,
  input  logic [DW-1:0]      data_i,
  input  logic [PAGE_LG-1:0] rd_idx_i,
  output logic [DW-1:0]      rd_data_o,
  output logic               pend_o,
  output logic [AW-1:0]      base_o,
  output logic [PAGE_LG:0]   cnt_o,
  output logic [DW-1:0]      first_o,
  output logic [AW-1:0]      cur_ptr_o
);
  localparam int PAGE = 1 << PAGE_LG;

  function automatic logic [AW-1:0] step_in_page(input logic [AW-1:0] a);
    logic [PAGE_LG-1:0] lo;
    lo = a[PAGE_LG-1:0] + 1'b1;
    return {a[AW-1:PAGE_LG], lo};
  endfunction

  logic               active_q, ptr_set_q;
  logic [AW-1:0]      base_q, cur_q;
  logic [PAGE_LG:0]   cnt_q;
  logic [DW-1:0]      first_q;
  logic [DW-1:0]      mem_q [PAGE];
  logic               take;

  assign take = data_we_i & active_q & ptr_set_q & ~start_i & ~stop_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      ptr_set_q <= 1'b0;
      base_q    <= '0;
      cur_q     <= '0;
      cnt_q     <= '0;
      first_q   <= '0;
    end else if (start_i || stop_i) begin
      active_q  <= 1'b0;
      ptr_set_q <= 1'b0;
      cnt_q     <= '0;
    end else if (open_i) begin
      active_q  <= 1'b1;
      ptr_set_q <= 1'b0;
      cnt_q     <= '0;
    end else if (ptr_load_i && active_q) begin
      base_q    <= ptr_i;
      cur_q     <= ptr_i;
      ptr_set_q <= 1'b1;
      cnt_q     <= '0;
    end else if (take) begin
      cur_q <= step_in_page(cur_q);
      if (cnt_q == '0) first_q <= data_i;
      if (cnt_q != (PAGE_LG+1)'(PAGE)) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (take) mem_q[cur_q[PAGE_LG-1:0]] <= data_i;
  end

  assign rd_data_o = mem_q[rd_idx_i];
  assign pend_o    = active_q & ptr_set_q & (cnt_q != '0);
  assign base_o    = base_q;
  assign cnt_o     = cnt_q;
  assign first_o   = first_q;
  assign cur_ptr_o = cur_q;

  assert_cnt_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= (PAGE_LG+1)'(PAGE));
  assert_page_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> cur_q[AW-1:PAGE_LG] == $past(cur_q[AW-1:PAGE_LG]));
endmodule

// File: rtl/pcc_commit.sv
module pcc_commit
  import pcc_pkg::*;
#(
  parameter int AW = 8,
  parameter int PAGE_LG = 4,
  parameter int PROG_CYCLES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               launch_i,
  input  logic [AW-1:0]      base_i,
  input  logic [PAGE_LG:0]   cnt_i,
  output logic [PAGE_LG-1:0] rd_idx_o,
  output logic [AW-1:0]      store_addr_o,
  output logic               store_we_o,
  output logic               busy_o
);
  localparam int TW = $clog2(PROG_CYCLES + 1);

  function automatic logic [AW-1:0] step_in_page(input logic [AW-1:0] a);
    logic [PAGE_LG-1:0] lo;
    lo = a[PAGE_LG-1:0] + 1'b1;
    return {a[AW-1:PAGE_LG], lo};
  endfunction

  commit_state_t    state_q;
  logic [AW-1:0]    addr_q;
  logic [PAGE_LG:0] left_q;
  logic [TW-1:0]    tmr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CS_IDLE;
      addr_q  <= '0;
      left_q  <= '0;
      tmr_q   <= '0;
    end else begin
      case (state_q)
        CS_IDLE: if (launch_i) begin
          state_q <= CS_WRITE;
          addr_q  <= base_i;
          left_q  <= cnt_i;
        end
        CS_WRITE: begin
          addr_q <= step_in_page(addr_q);
          left_q <= left_q - 1'b1;
          if (left_q == (PAGE_LG+1)'(1)) begin
            state_q <= CS_PROG;
            tmr_q   <= TW'(PROG_CYCLES - 1);
          end
        end
        CS_PROG: begin
          if (tmr_q == '0) state_q <= CS_IDLE;
          else             tmr_q   <= tmr_q - 1'b1;
        end
        default: state_q <= CS_IDLE;
      endcase
    end
  end

  assign store_we_o   = (state_q == CS_WRITE);
  assign busy_o       = (state_q != CS_IDLE);
  assign store_addr_o = addr_q;
  assign rd_idx_o     = addr_q[PAGE_LG-1:0];

  assert_launch_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    launch_i |-> !busy_o);
  assert_wr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    store_we_o && $past(store_we_o) |->
      store_addr_o == step_in_page($past(store_addr_o)));
endmodule

// File: rtl/pcc_top.sv
module pcc_top #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int PAGE_LG = 4,
  parameter int PROG_CYCLES = 8,
  parameter logic [AW-1:0] PROT_ADDR = 8'h42
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          addr_hit_i,
  input  logic          ptr_load_i,
  input  logic [AW-1:0] ptr_i,
  input  logic          data_we_i,
  input  logic [DW-1:0] data_i,
  output logic          addr_ack_o,
  output logic [AW-1:0] rd_ptr_o,
  output logic [AW-1:0] store_addr_o,
  output logic [DW-1:0] store_data_o,
  output logic          store_we_o,
  output logic          busy_o,
  output logic          refused_o
);
  logic               open_w, pend_w, is_prot_w, region_ok_w;
  logic               launch_w, refuse_w, prot_ld_w;
  logic               mem_open_w, cfg_open_w;
  logic [AW-1:0]      base_w;
  logic [PAGE_LG:0]   cnt_w;
  logic [DW-1:0]      first_w;
  logic [PAGE_LG-1:0] rd_idx_w;
  logic               refused_q;

  assign open_w     = addr_hit_i & ~busy_o;
  assign addr_ack_o = open_w;

  pcc_pagebuf #(.AW(AW), .DW(DW), .PAGE_LG(PAGE_LG)) u_buf (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .open_i(open_w), .ptr_load_i(ptr_load_i), .ptr_i(ptr_i),
    .data_we_i(data_we_i), .data_i(data_i), .rd_idx_i(rd_idx_w),
    .rd_data_o(store_data_o), .pend_o(pend_w), .base_o(base_w),
    .cnt_o(cnt_w), .first_o(first_w), .cur_ptr_o(rd_ptr_o)
  );

  assign is_prot_w   = (base_w == PROT_ADDR);
  assign region_ok_w = base_w[AW-1] ? mem_open_w : cfg_open_w;
  assign launch_w    = stop_i & pend_w & ~is_prot_w & region_ok_w;
  assign refuse_w    = stop_i & pend_w & ~is_prot_w & ~region_ok_w;
  assign prot_ld_w   = stop_i & pend_w & is_prot_w;

  pcc_protect u_prot (
    .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .load_i(prot_ld_w),
    .val_i(first_w[7:0]), .mem_open_o(mem_open_w), .cfg_open_o(cfg_open_w)
  );

  pcc_commit #(.AW(AW), .PAGE_LG(PAGE_LG), .PROG_CYCLES(PROG_CYCLES)) u_cmt (
    .clk(clk), .rst_n(rst_n), .launch_i(launch_w), .base_i(base_w),
    .cnt_i(cnt_w), .rd_idx_o(rd_idx_w), .store_addr_o(store_addr_o),
    .store_we_o(store_we_o), .busy_o(busy_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        refused_q <= 1'b0;
    else if (refuse_w) refused_q <= 1'b1;
  end
  assign refused_o = refused_q;

  assert_we_after_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(store_we_o) |-> $past(stop_i));
  assert_refused_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    refused_o |=> refused_o);
  assert_busy_from_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(stop_i));
endmodule

// File: tb/sim_pcc_top.sv
module sim_pcc_top;
  localparam int CLK_NS = 10;
  localparam int PROG = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, stop_i = 0, addr_hit_i = 0, ptr_load_i = 0, data_we_i = 0;
  logic [7:0] ptr_i = 0, data_i = 0;
  logic addr_ack_o, store_we_o, busy_o, refused_o;
  logic [7:0] rd_ptr_o, store_addr_o, store_data_o;

  pcc_top #(.PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .addr_hit_i(addr_hit_i), .ptr_load_i(ptr_load_i), .ptr_i(ptr_i),
    .data_we_i(data_we_i), .data_i(data_i), .addr_ack_o(addr_ack_o),
    .rd_ptr_o(rd_ptr_o), .store_addr_o(store_addr_o),
    .store_data_o(store_data_o), .store_we_o(store_we_o),
    .busy_o(busy_o), .refused_o(refused_o)
  );

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int wn = 0, bn = 0;
  logic [7:0] mm [256];
  logic [7:0] la [64];
  logic [7:0] ld [64];
  bit done = 0;

  always @(negedge clk) begin
    if (rst_n && store_we_o) begin
      mm[store_addr_o] = store_data_o;
      if (wn < 64) begin la[wn] = store_addr_o; ld[wn] = store_data_o; end
      wn = wn + 1;
    end
    if (rst_n && busy_o) bn = bn + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic quiet();
    start_i = 0; stop_i = 0; addr_hit_i = 0; ptr_load_i = 0; data_we_i = 0;
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
  endtask

  task automatic clear_log();
    wn = 0; bn = 0;
  endtask

  // Start, address hit, pointer, n data bytes (d0+i), then Stop or repeated Start.
  task automatic send(input logic [7:0] p, input int n, input logic [7:0] d0,
                      input bit with_stop);
    @(negedge clk) quiet(); start_i = 1;
    @(negedge clk) quiet(); addr_hit_i = 1;
    @(negedge clk) quiet(); ptr_load_i = 1; ptr_i = p;
    for (int i = 0; i < n; i++) begin
      @(negedge clk) quiet(); data_we_i = 1; data_i = d0 + 8'(i);
    end
    @(negedge clk) quiet();
    if (with_stop) stop_i = 1; else start_i = 1;
    @(negedge clk) quiet();
  endtask

  task automatic t_reset();
    chk(busy_o == 0, "R1 busy", busy_o, 0);
    chk(refused_o == 0, "R1 refused", refused_o, 0);
    chk(store_we_o == 0, "R1 we", store_we_o, 0);
  endtask

  task automatic t_locked_cfg();
    clear_log();
    send(8'h10, 1, 8'hAA, 1); settle();
    chk(wn == 0, "R1 locked cfg writes", wn, 0);
    chk(bn == 0, "R7 no busy", bn, 0);
    chk(refused_o == 1, "R7 refused set", refused_o, 1);
  endtask

  task automatic t_unlock_cfg();
    clear_log();
    send(8'h42, 1, 8'h05, 1); settle();
    chk(wn == 0 && bn == 0, "R5 prot write no commit", wn + bn, 0);
    clear_log();
    send(8'h10, 3, 8'h21, 1); settle();
    chk(wn == 3, "R2 write count", wn, 3);
    for (int i = 0; i < 3; i++) begin
      chk(la[i] == 8'h10 + 8'(i), "R2 address order", la[i], 8'h10 + i);
      chk(ld[i] == 8'h21 + 8'(i), "R2 data order", ld[i], 8'h21 + i);
    end
    chk(bn == 3 + PROG, "R8 busy length", bn, 3 + PROG);
    chk(refused_o == 1, "R7 sticky", refused_o, 1);
  endtask

  task automatic t_mem_locked();
    clear_log();
    send(8'h90, 2, 8'h31, 1); settle();
    chk(wn == 0, "R6 memory still locked", wn, 0);
  endtask

  task automatic t_wrap();
    clear_log();
    send(8'h42, 1, 8'h55, 1); settle();
    clear_log();
    send(8'h8E, 4, 8'h40, 1); settle();
    chk(wn == 4, "R3 wrap count", wn, 4);
    chk(la[0] == 8'h8E && la[1] == 8'h8F, "R3 before wrap", {la[0], la[1]}, 16'h8E8F);
    chk(la[2] == 8'h80 && la[3] == 8'h81, "R3 after wrap", {la[2], la[3]}, 16'h8081);
    chk(mm[8'h80] == 8'h42, "R3 wrapped data", mm[8'h80], 8'h42);
    chk(bn == 4 + PROG, "R8 busy length 4", bn, 4 + PROG);
  endtask

  task automatic t_overflow();
    clear_log();
    send(8'hA0, 17, 8'h10, 1); settle();
    chk(wn == 16, "R3 overflow count", wn, 16);
    chk(mm[8'hA0] == 8'h20, "R3 overwritten slot", mm[8'hA0], 8'h20);
    chk(mm[8'hAF] == 8'h1F, "R3 last slot", mm[8'hAF], 8'h1F);
    chk(mm[8'hA1] == 8'h11, "R3 second slot", mm[8'hA1], 8'h11);
    chk(bn == 16 + PROG, "R8 busy length 16", bn, 16 + PROG);
  endtask

  task automatic t_rep_start();
    clear_log();
    send(8'h33, 2, 8'h60, 0); settle();
    chk(wn == 0, "R4 no write on repeated start", wn, 0);
    chk(rd_ptr_o == 8'h35, "R4 pointer kept", rd_ptr_o, 8'h35);
    @(negedge clk) quiet(); stop_i = 1;
    @(negedge clk) quiet(); settle();
    chk(wn == 0 && bn == 0, "R4 later stop idle", wn + bn, 0);
    send(8'h77, 0, 8'h00, 0); settle();
    chk(rd_ptr_o == 8'h77, "R4 dummy write pointer", rd_ptr_o, 8'h77);
  endtask

  task automatic t_busy_nack();
    clear_log();
    send(8'h18, 2, 8'h70, 1);
    chk(busy_o == 1, "R8 busy after stop", busy_o, 1);
    addr_hit_i = 1; #1;
    chk(addr_ack_o == 0, "R8 no ack while busy", addr_ack_o, 0);
    @(negedge clk) quiet(); ptr_load_i = 1; ptr_i = 8'h60;
    @(negedge clk) quiet(); data_we_i = 1; data_i = 8'hEE;
    @(negedge clk) quiet(); stop_i = 1;
    @(negedge clk) quiet(); settle();
    chk(wn == 2, "R8 ignored transaction", wn, 2);
    chk(mm[8'h60] == 8'h00, "R8 cell untouched", mm[8'h60], 0);
    addr_hit_i = 1; #1;
    chk(addr_ack_o == 1, "R8 ack when idle", addr_ack_o, 1);
    quiet();
  endtask

  task automatic t_relock();
    clear_log();
    send(8'h42, 1, 8'h5A, 1); settle();
    send(8'h20, 1, 8'h99, 1); settle();
    chk(wn == 0, "R6 config relocked", wn, 0);
    send(8'hC0, 1, 8'h9B, 1); settle();
    chk(wn == 1 && mm[8'hC0] == 8'h9B, "R6 memory open", mm[8'hC0], 8'h9B);
  endtask

  task automatic t_empty();
    clear_log();
    send(8'hC5, 0, 8'h00, 1); settle();
    chk(wn == 0 && bn == 0, "R9 stop without data", wn + bn, 0);
    chk(rd_ptr_o == 8'hC5, "R9 pointer", rd_ptr_o, 8'hC5);
    @(negedge clk) quiet(); ptr_load_i = 1; ptr_i = 8'hD0;
    @(negedge clk) quiet(); data_we_i = 1; data_i = 8'h11;
    @(negedge clk) quiet(); stop_i = 1;
    @(negedge clk) quiet(); settle();
    chk(wn == 0, "R9 no acked address", wn, 0);
    chk(rd_ptr_o == 8'hC5, "R9 pointer unchanged", rd_ptr_o, 8'hC5);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mm[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_locked_cfg();
    t_unlock_cfg();
    t_mem_locked();
    t_wrap();
    t_overflow();
    t_rep_start();
    t_busy_nack();
    t_relock();
    t_empty();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule